// File: doc/BRIEF.md
# Sixteen-Operation ALU with Status Flags

This block is the arithmetic and logic datapath of a small single-cycle processor. A 4-bit operation code selects one of sixteen slots. The slots cover the bitwise operations, add, subtract, a truncated multiply, an unsigned divide, and a pass-through of the second operand that the move instructions use. Three status bits (zero, negative, positive) are derived from the selected result. The conditional jumps in the core test these bits. The core also holds any copy of them.

The block is purely combinational. There is no clock, no reset and no handshake. The result and flags follow the operands and the code within the same cycle, and the surrounding core registers them. The operand width is a parameter, so narrow copies can be built. The default build is 16 bits.

Top module: `op16_alu`

## Requirements
- R1: Code 0 gives A OR B, code 2 gives A AND B, and code 3 gives A XOR B, each bit by bit.
- R2: Code 1 gives the bitwise inverse of A. For code 1 the value of B has no effect on any output.
- R3: Code 4 gives (A + B) mod 2^WIDTH and code 5 gives (A − B) mod 2^WIDTH.
- R4: Code 6 gives the low WIDTH bits of the unsigned product A × B.
- R5: Code 7 gives floor(A / B), with both operands treated as unsigned, when B is nonzero.
- R6: Code 7 with B equal to zero gives all ones (0xFFFF at the default width).
- R7: Codes 8 and 9 both give B unchanged, whatever the value of A.
- R8: Codes 10 to 15 give a result of zero.
- R9: zero_o is 1 exactly when the result is all zeros.
- R10: neg_o equals the result's top bit (bit WIDTH−1).
- R11: pos_o is 1 exactly when the result is nonzero and its top bit is 0. For every input, exactly one of the three flags is 1.
- R12: The result and flags hold no state. They reflect the current inputs in the same cycle that those inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | WIDTH | First operand (destination register value) |
| b_i | input | WIDTH | Second operand (source register or immediate) |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result top bit set |
| pos_o | output | 1 | Result nonzero with top bit clear |

## Verification
The bench builds two copies of the block. One has WIDTH set to 4. Its full input space is 16 codes × 16 × 16 operand values, so the bench checks every carry, every wrap of the multiply, every quotient and every divide by zero against plain integer arithmetic. The second copy keeps the default width of 16 and is swept over all codes with operand patterns at the sign boundary (0x7FFF, 0x8000), all ones, zero, one, 0x00FF and two mixed words. This covers the sign flags and the wide wrap-around cases at full size.

// File: rtl/op16_alu_pkg.sv
package op16_alu_pkg;
  localparam int unsigned OP_BITS = 4;

  typedef enum logic [OP_BITS-1:0] {
    OP_OR   = 4'd0,
    OP_NOT  = 4'd1,
    OP_AND  = 4'd2,
    OP_XOR  = 4'd3,
    OP_ADD  = 4'd4,
    OP_SUB  = 4'd5,
    OP_MUL  = 4'd6,
    OP_DIV  = 4'd7,
    OP_MOVR = 4'd8,
    OP_MOVI = 4'd9
  } alu_op_e;
endpackage

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [1:0]       sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  // sel_i matches the low two bits of codes 0..3
  always_comb begin
    unique case (sel_i)
      2'd0:    y_o = a_i | b_i;
      2'd1:    y_o = ~a_i;
      2'd2:    y_o = a_i & b_i;
      default: y_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             sub_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] prod_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   sum_full;
  logic [2*WIDTH-1:0] prod_full;

  // one adder serves both add and subtract (two's complement)
  assign b_eff     = sub_i ? ~b_i : b_i;
  assign sum_full  = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign sum_o     = sum_full[WIDTH-1:0];

  assign prod_full = {{WIDTH{1'b0}}, a_i} * {{WIDTH{1'b0}}, b_i};
  assign prod_o    = prod_full[WIDTH-1:0];
endmodule

// File: rtl/alu_divider.sv
module alu_divider #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] num_i,
  input  logic [WIDTH-1:0] den_i,
  output logic [WIDTH-1:0] quo_o
);
  localparam int unsigned RW = WIDTH + 1;

  // restoring array: one trial subtract per quotient bit
  logic [RW-1:0] part [WIDTH+1];
  logic [WIDTH-1:0] qbit;

  assign part[WIDTH] = '0;

  for (genvar s = WIDTH - 1; s >= 0; s--) begin : g_stage
    logic [RW-1:0] shifted;
    logic [RW-1:0] diff;
    assign shifted = {part[s+1][WIDTH-1:0], num_i[s]};
    assign diff    = shifted - {1'b0, den_i};
    assign qbit[s] = ~diff[RW-1];
    assign part[s] = qbit[s] ? diff : shifted;
  end

  // a zero divisor makes every trial succeed, so the quotient is all ones
  assign quo_o = qbit;

  logic unused_rem;
  assign unused_rem = ^part[0];
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] res_i,
  output logic             zero_o,
  output logic             neg_o,
  output logic             pos_o
);
  logic any_set;

  assign any_set = |res_i;
  assign zero_o  = ~any_set;
  assign neg_o   = res_i[WIDTH-1];
  assign pos_o   = any_set & ~res_i[WIDTH-1];
endmodule

// File: rtl/op16_alu.sv
module op16_alu
  import op16_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             pos_o
);
  logic [WIDTH-1:0] bit_y;
  logic [WIDTH-1:0] sum_y;
  logic [WIDTH-1:0] prod_y;
  logic [WIDTH-1:0] quo_y;
  logic [WIDTH-1:0] res;

  alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .sel_i (op_i[1:0]),
    .a_i   (a_i),
    .b_i   (b_i),
    .y_o   (bit_y)
  );

  alu_arith #(.WIDTH(WIDTH)) u_arith (
    .sub_i  (op_i[0]),
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_o  (sum_y),
    .prod_o (prod_y)
  );

  alu_divider #(.WIDTH(WIDTH)) u_divider (
    .num_i (a_i),
    .den_i (b_i),
    .quo_o (quo_y)
  );

  always_comb begin
    case (op_i)
      OP_OR, OP_NOT, OP_AND, OP_XOR: res = bit_y;
      OP_ADD, OP_SUB:                res = sum_y;
      OP_MUL:                        res = prod_y;
      OP_DIV:                        res = quo_y;
      OP_MOVR, OP_MOVI:              res = b_i;
      default:                       res = '0;
    endcase
  end

  assign result_o = res;

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .res_i  (res),
    .zero_o (zero_o),
    .neg_o  (neg_o),
    .pos_o  (pos_o)
  );
endmodule

// File: rtl/op16_alu_checker.sv
module op16_alu_checker #(
  parameter int unsigned WIDTH = 16
) (
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             neg_o,
  input logic             pos_o
);
  always_comb begin
    p_one_flag_r11: assert ($onehot({zero_o, neg_o, pos_o}))
      else $error("flags not one-hot");
    p_zero_flag_r9: assert (zero_o == (result_o == '0))
      else $error("zero flag disagrees with result");
    p_neg_flag_r10: assert (neg_o == result_o[WIDTH-1])
      else $error("negative flag disagrees with result");
    if (op_i == 4'd1) begin
      p_invert_r2: assert (result_o == ~a_i)
        else $error("code 1 result is not inverse of A");
    end
    if (op_i == 4'd8 || op_i == 4'd9) begin
      p_move_r7: assert (result_o == b_i)
        else $error("move result is not B");
    end
    if (op_i == 4'd7 && b_i == '0) begin
      p_div_zero_r6: assert (result_o == {WIDTH{1'b1}})
        else $error("divide by zero result is not all ones");
    end
    if (op_i >= 4'd10) begin
      p_spare_zero_r8: assert (result_o == '0)
        else $error("spare code result is not zero");
    end
  end
endmodule

bind op16_alu op16_alu_checker #(.WIDTH(WIDTH)) i_chk (
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .neg_o    (neg_o),
  .pos_o    (pos_o)
);

// File: tb/test_op16_alu.sv
module test_op16_alu;
  localparam int unsigned WL = 16;
  localparam int unsigned WS = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [3:0]    op_l = '0;
  logic [WL-1:0] a_l  = '0;
  logic [WL-1:0] b_l  = '0;
  logic [WL-1:0] r_l;
  logic z_l, n_l, p_l;

  logic [3:0]    op_s = '0;
  logic [WS-1:0] a_s  = '0;
  logic [WS-1:0] b_s  = '0;
  logic [WS-1:0] r_s;
  logic z_s, n_s, p_s;

  op16_alu #(.WIDTH(WL)) i_op16_alu (
    .op_i(op_l), .a_i(a_l), .b_i(b_l),
    .result_o(r_l), .zero_o(z_l), .neg_o(n_l), .pos_o(p_l)
  );

  op16_alu #(.WIDTH(WS)) i_op16_alu_w4 (
    .op_i(op_s), .a_i(a_s), .b_i(b_s),
    .result_o(r_s), .zero_o(z_s), .neg_o(n_s), .pos_o(p_s)
  );

  function automatic string req_of(int op);
    case (op)
      0, 2, 3: return "R1";
      1:       return "R2";
      4, 5:    return "R3";
      6:       return "R4";
      7:       return "R5/R6";
      8, 9:    return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic longint model(int op, longint a, longint b, int w);
    longint m = (longint'(1) << w) - 1;
    case (op)
      0: return (a | b) & m;
      1: return (~a) & m;
      2: return (a & b) & m;
      3: return (a ^ b) & m;
      4: return (a + b) & m;
      5: return (a - b) & m;
      6: return (a * b) & m;
      7: return (b == 0) ? m : (a / b);
      8, 9: return b & m;
      default: return 0;
    endcase
  endfunction

  task automatic judge(int w, int op, longint a, longint b, longint got,
                       logic gz, logic gn, logic gp);
    longint exp_r = model(op, a, b, w);
    logic ez = (exp_r == 0);
    logic en = exp_r[w-1];
    logic ep = (exp_r != 0) && !exp_r[w-1];
    n_checks++;
    if (got != exp_r) begin
      n_fail++;
      $display("FAIL %s R12 w=%0d op=%0d a=%0h b=%0h result actual=%0h expected=%0h",
               req_of(op), w, op, a, b, got, exp_r);
    end
    n_checks++;
    if ({gz, gn, gp} !== {ez, en, ep}) begin
      n_fail++;
      $display("FAIL R9/R10/R11 w=%0d op=%0d a=%0h b=%0h znp actual=%b expected=%b",
               w, op, a, b, {gz, gn, gp}, {ez, en, ep});
    end
  endtask

  initial begin
    longint pat[8] = '{64'h0000, 64'h0001, 64'h7FFF, 64'h8000,
                       64'hFFFF, 64'h00FF, 64'h1234, 64'hABCD};
    // idle state with all inputs zero: OR of zeros, zero flag only (R9)
    @(negedge clk);
    judge(WL, 0, 0, 0, r_l, z_l, n_l, p_l);

    // exhaustive sweep of the narrow copy: all R1..R12 at WIDTH 4
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          @(posedge clk);
          op_s = 4'(op); a_s = WS'(a); b_s = WS'(b);
          @(negedge clk);
          judge(WS, op, a, b, r_s, z_s, n_s, p_s);
        end

    // boundary patterns at full width, R1..R11
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          @(posedge clk);
          op_l = 4'(op); a_l = WL'(pat[i]); b_l = WL'(pat[j]);
          @(negedge clk);
          judge(WL, op, pat[i], pat[j], r_l, z_l, n_l, p_l);
        end

    // R2: B changed under code 1 with A held, result must stay ~A
    @(posedge clk);
    op_l = 4'd1; a_l = 16'h5A3C; b_l = 16'h0000;
    @(negedge clk);
    judge(WL, 1, 64'h5A3C, 0, r_l, z_l, n_l, p_l);
    @(posedge clk);
    b_l = 16'hFFFF;
    @(negedge clk);
    judge(WL, 1, 64'h5A3C, 64'hFFFF, r_l, z_l, n_l, p_l);

    // R6: divide by zero at full width
    @(posedge clk);
    op_l = 4'd7; a_l = 16'h0000; b_l = 16'h0000;
    @(negedge clk);
    judge(WL, 7, 0, 0, r_l, z_l, n_l, p_l);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R12 watchdog expired actual=running expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule